// File: doc/BRIEF.md
# Packed Instruction Bundle Sequencer

The sequencer sits between instruction fetch and decode in a core whose instructions come in 128-bit bundles. Each bundle carries three 42-bit instruction slots plus a 2-bit control field. The sequencer accepts one bundle at a time over a valid/ready fetch port. It hands the slots to the decoder one per cycle over a valid/ready issue port, and the slot position counts 0, 1, 2 and then returns to 0 for the next bundle.

The two control bits act on the whole bundle. The extension bit turns the final slot into a wide immediate. That immediate travels with slot 0 as its first operand, and the final slot is never issued as an instruction. The conditional bit makes slots 0 and 1 depend on the most recent compare result. A slot whose condition fails still goes out on the issue port, with a kill flag raised, so the decoder sees uniform timing. A new bundle is taken in during the same cycle that the last slot of the current bundle is accepted, so no bubble appears between bundles.

Top module: `bundle_sequencer`

## Requirements
- R1: Slot k of a bundle sits at bits [42k+41:42k]. When issued, it appears on `issue_slot` with `issue_idx` equal to k.
- R2: Slots of one bundle issue in the order 0, 1, 2. After the last slot of a bundle is accepted, the index returns to 0 for the next bundle.
- R3: When bit 126 (extension bit) is set, slot 2 is never issued. The sequence goes from slot 1 straight to the next bundle, and during slot 0 `issue_imm_valid` is 1 and `issue_imm` carries bits [125:84].
- R4: When bit 126 is clear, or during slots other than 0, `issue_imm_valid` is 0 and `issue_imm` is zero.
- R5: When bit 127 (conditional bit) is set, `issue_kill` on slots 0 and 1 equals the inverse of `cmp_flag`, sampled combinationally in the issue cycle of each slot. Slot 2 is never killed, and no slot is killed when bit 127 is clear.
- R6: A killed slot is still presented with `issue_valid` high and its slot bits intact.
- R7: While `issue_valid` is high and `issue_ready` is low, the issued slot, index, immediate and valid stay unchanged, and `fetch_ready` is low.
- R8: `fetch_ready` is high when no bundle is held, and also in the cycle the final slot is accepted. A bundle offered in that cycle appears at index 0 in the very next cycle, with no bubble.
- R9: While reset is asserted, `issue_valid` is 0. Any partly issued bundle is discarded, and the next bundle starts at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fetch_valid | input | 1 | Bundle offered by fetch |
| fetch_ready | output | 1 | Sequencer can take a bundle |
| fetch_bundle | input | 128 | Bundle: three slots plus control bits [127:126] |
| cmp_flag | input | 1 | Most recent compare succeeded |
| issue_valid | output | 1 | A slot is presented |
| issue_ready | input | 1 | Decoder accepts the slot |
| issue_slot | output | 42 | Slot bits |
| issue_idx | output | 2 | Slot position within the bundle |
| issue_imm | output | 42 | Attached wide immediate |
| issue_imm_valid | output | 1 | Immediate attached to this slot |
| issue_kill | output | 1 | Slot failed its condition |

## Verification
The bench builds the block with its default parameters: three slots of 42 bits, which gives the 128-bit bundle with the control pair at the top. With that geometry every combination of the two control bits can be reached, including the shortened two-slot sequence and a per-slot change of the compare flag inside one bundle. The bench also covers back-pressure that holds slot 0, a fetch that overlaps the final slot of both the three-slot and the two-slot sequence, and a reset that arrives mid-bundle.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
    localparam int unsigned CTRL_W = 2;

    // Control pair, MSB first: conditional bit then extension bit.
    typedef struct packed {
        logic cond;
        logic imm;
    } bseq_ctrl_t;
endpackage

// File: rtl/bseq_slot_mux.sv
module bseq_slot_mux #(
    parameter int unsigned SLOT_W = 42,
    parameter int unsigned NSLOT  = 3,
    localparam int unsigned IDX_W  = $clog2(NSLOT),
    localparam int unsigned BODY_W = SLOT_W * NSLOT
) (
    input  logic [BODY_W-1:0] body,
    input  logic [IDX_W-1:0]  idx,
    output logic [SLOT_W-1:0] slot,
    output logic [SLOT_W-1:0] tail_slot
);
    logic [SLOT_W-1:0] slots [NSLOT];

    for (genvar g = 0; g < NSLOT; g++) begin : g_unpack
        assign slots[g] = body[g*SLOT_W +: SLOT_W];
    end

    always_comb begin
        slot = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (idx == IDX_W'(i)) slot = slots[i];
        end
    end

    assign tail_slot = slots[NSLOT-1];
endmodule

// File: rtl/bseq_ctrl_decode.sv
module bseq_ctrl_decode
    import bseq_pkg::*;
#(
    parameter int unsigned NSLOT = 3,
    localparam int unsigned IDX_W = $clog2(NSLOT)
) (
    input  bseq_ctrl_t       ctrl,
    input  logic [IDX_W-1:0] idx,
    input  logic             cmp_flag,
    output logic             is_last,
    output logic             kill,
    output logic             imm_attach
);
    localparam logic [IDX_W-1:0] LAST_FULL  = IDX_W'(NSLOT - 1);
    localparam logic [IDX_W-1:0] LAST_SHORT = IDX_W'(NSLOT - 2);

    logic [IDX_W-1:0] last_idx;

    always_comb begin
        last_idx   = ctrl.imm ? LAST_SHORT : LAST_FULL;
        is_last    = (idx == last_idx);
        kill       = ctrl.cond && (idx < LAST_FULL) && !cmp_flag;
        imm_attach = ctrl.imm && (idx == '0);
    end
endmodule

// File: rtl/bundle_sequencer.sv
module bundle_sequencer
    import bseq_pkg::*;
#(
    parameter int unsigned SLOT_W = 42,
    parameter int unsigned NSLOT  = 3,
    localparam int unsigned IDX_W    = $clog2(NSLOT),
    localparam int unsigned BODY_W   = SLOT_W * NSLOT,
    localparam int unsigned BUNDLE_W = BODY_W + CTRL_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fetch_valid,
    output logic                fetch_ready,
    input  logic [BUNDLE_W-1:0] fetch_bundle,
    input  logic                cmp_flag,
    output logic                issue_valid,
    input  logic                issue_ready,
    output logic [SLOT_W-1:0]   issue_slot,
    output logic [IDX_W-1:0]    issue_idx,
    output logic [SLOT_W-1:0]   issue_imm,
    output logic                issue_imm_valid,
    output logic                issue_kill
);
    typedef struct packed {
        logic                have;
        logic [IDX_W-1:0]    idx;
        logic [BUNDLE_W-1:0] bundle;
    } seq_t;

    seq_t st_d, st_q;

    bseq_ctrl_t        ctrl_q;
    logic [SLOT_W-1:0] cur_slot;
    logic [SLOT_W-1:0] tail_slot;
    logic              is_last;
    logic              kill_raw;
    logic              imm_attach;
    logic              issue_fire;

    assign ctrl_q = bseq_ctrl_t'(st_q.bundle[BUNDLE_W-1 -: CTRL_W]);

    bseq_slot_mux #(.SLOT_W(SLOT_W), .NSLOT(NSLOT)) u_mux (
        .body      (st_q.bundle[BODY_W-1:0]),
        .idx       (st_q.idx),
        .slot      (cur_slot),
        .tail_slot (tail_slot)
    );

    bseq_ctrl_decode #(.NSLOT(NSLOT)) u_dec (
        .ctrl       (ctrl_q),
        .idx        (st_q.idx),
        .cmp_flag   (cmp_flag),
        .is_last    (is_last),
        .kill       (kill_raw),
        .imm_attach (imm_attach)
    );

    always_comb begin
        issue_valid     = st_q.have;
        issue_slot      = cur_slot;
        issue_idx       = st_q.idx;
        issue_imm_valid = st_q.have && imm_attach;
        issue_imm       = issue_imm_valid ? tail_slot : '0;
        issue_kill      = st_q.have && kill_raw;
        issue_fire      = st_q.have && issue_ready;
        fetch_ready     = !st_q.have || (issue_ready && is_last);

        st_d = st_q;
        if (issue_fire) begin
            if (is_last) begin
                st_d.have = 1'b0;
                st_d.idx  = '0;
            end else begin
                st_d.idx = st_q.idx + IDX_W'(1);
            end
        end
        if (fetch_valid && fetch_ready) begin
            st_d.have   = 1'b1;
            st_d.idx    = '0;
            st_d.bundle = fetch_bundle;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/bseq_checker.sv
module bseq_checker #(
    parameter int unsigned SLOT_W = 42,
    parameter int unsigned NSLOT  = 3,
    localparam int unsigned IDX_W = $clog2(NSLOT)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fetch_ready,
    input logic              issue_valid,
    input logic              issue_ready,
    input logic [SLOT_W-1:0] issue_slot,
    input logic [IDX_W-1:0]  issue_idx,
    input logic              issue_imm_valid,
    input logic              issue_kill
);
    a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid && !issue_ready |=> issue_valid && $stable(issue_slot) && $stable(issue_idx));

    a_r7_no_fetch_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid && !issue_ready |-> !fetch_ready);

    a_r2_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> issue_idx < IDX_W'(NSLOT));

    a_r2_step_after_first: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid && issue_ready && issue_idx == '0 && !fetch_ready
        |=> issue_valid && issue_idx == IDX_W'(1));

    a_r3_imm_only_slot0: assert property (@(posedge clk) disable iff (!rst_n)
        issue_imm_valid |-> issue_valid && issue_idx == '0);

    a_r5_last_never_killed: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid && issue_idx == IDX_W'(NSLOT - 1) |-> !issue_kill);

    a_r8_empty_accepts: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |-> fetch_ready);
endmodule

bind bundle_sequencer bseq_checker #(.SLOT_W(SLOT_W), .NSLOT(NSLOT)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .fetch_ready     (fetch_ready),
    .issue_valid     (issue_valid),
    .issue_ready     (issue_ready),
    .issue_slot      (issue_slot),
    .issue_idx       (issue_idx),
    .issue_imm_valid (issue_imm_valid),
    .issue_kill      (issue_kill)
);

// File: tb/bundle_sequencer_test.sv
module bundle_sequencer_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         fetch_valid = 1'b0;
    logic         fetch_ready;
    logic [127:0] fetch_bundle = '0;
    logic         cmp_flag = 1'b0;
    logic         issue_valid;
    logic         issue_ready = 1'b1;
    logic [41:0]  issue_slot;
    logic [1:0]   issue_idx;
    logic [41:0]  issue_imm;
    logic         issue_imm_valid;
    logic         issue_kill;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    bundle_sequencer uut (
        .clk(clk), .rst_n(rst_n),
        .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_bundle(fetch_bundle),
        .cmp_flag(cmp_flag),
        .issue_valid(issue_valid), .issue_ready(issue_ready),
        .issue_slot(issue_slot), .issue_idx(issue_idx),
        .issue_imm(issue_imm), .issue_imm_valid(issue_imm_valid), .issue_kill(issue_kill)
    );

    // Vector: {cond bit, ext bit, cmp for slot2, slot1, slot0}
    localparam logic [4:0] VEC [10] = '{
        5'b00_000, 5'b00_111, 5'b01_000, 5'b01_101,
        5'b10_111, 5'b10_000, 5'b10_010, 5'b11_001,
        5'b11_110, 5'b10_101
    };

    function automatic logic [41:0] mk_slot(int v, int k);
        return {26'(v * 3 + 5), 4'hA, 4'(k), 8'(255 - v)};
    endfunction

    function automatic logic [127:0] mk_bundle(int v, logic [1:0] ctrl);
        return {ctrl, mk_slot(v, 2), mk_slot(v, 1), mk_slot(v, 0)};
    endfunction

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    task automatic send(logic [127:0] b);
        @(negedge clk);
        fetch_valid  = 1'b1;
        fetch_bundle = b;
        while (!fetch_ready) @(negedge clk);
        @(posedge clk);
        #1 fetch_valid = 1'b0;
    endtask

    // Check the slot presented at the current negedge.
    task automatic check_slot(int v, int k, logic [1:0] ctrl, logic cmp);
        logic exp_kill;
        logic [41:0] exp_imm;
        exp_kill = ctrl[1] && (k < 2) && !cmp;
        exp_imm  = (ctrl[0] && k == 0) ? mk_slot(v, 2) : 42'd0;
        chk(issue_valid == 1'b1, "R6 valid", 64'(issue_valid), 64'd1);
        chk(issue_slot == mk_slot(v, k), "R1 slot bits", 64'(issue_slot), 64'(mk_slot(v, k)));
        chk(issue_idx == 2'(k), "R2 index", 64'(issue_idx), 64'(k));
        chk(issue_kill == exp_kill, "R5 kill", 64'(issue_kill), 64'(exp_kill));
        chk(issue_imm_valid == (ctrl[0] && k == 0), "R3 imm valid",
            64'(issue_imm_valid), 64'(ctrl[0] && k == 0));
        chk(issue_imm == exp_imm, "R4 imm value", 64'(issue_imm), 64'(exp_imm));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(issue_valid == 1'b0, "R9 reset valid", 64'(issue_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(issue_valid == 1'b0, "R9 empty after reset", 64'(issue_valid), 64'd0);
        chk(fetch_ready == 1'b1, "R8 ready when empty", 64'(fetch_ready), 64'd1);

        // Table walk
        for (int v = 0; v < 10; v++) begin
            logic [1:0] ctrl;
            int nslots;
            ctrl   = VEC[v][4:3];
            nslots = ctrl[0] ? 2 : 3;
            send(mk_bundle(v, ctrl));
            for (int k = 0; k < nslots; k++) begin
                @(negedge clk);
                cmp_flag = VEC[v][k];
                #1;
                check_slot(v, k, ctrl, VEC[v][k]);
            end
            @(negedge clk);
            chk(issue_valid == 1'b0, "R3 R2 bundle ends", 64'(issue_valid), 64'd0);
        end

        // Back-pressure holds slot 0 (R7)
        issue_ready = 1'b0;
        send(mk_bundle(20, 2'b00));
        repeat (3) @(negedge clk);
        chk(issue_idx == 2'd0 && issue_slot == mk_slot(20, 0), "R7 held slot",
            64'(issue_slot), 64'(mk_slot(20, 0)));
        chk(fetch_ready == 1'b0, "R7 fetch blocked", 64'(fetch_ready), 64'd0);
        issue_ready = 1'b1;

        // Overlap on the final slot of a 3-slot bundle (R8)
        @(negedge clk);
        chk(issue_idx == 2'd1, "R2 step after stall", 64'(issue_idx), 64'd1);
        @(negedge clk);
        chk(issue_idx == 2'd2, "R2 last slot", 64'(issue_idx), 64'd2);
        fetch_valid  = 1'b1;
        fetch_bundle = mk_bundle(21, 2'b01);
        #1 chk(fetch_ready == 1'b1, "R8 ready on last", 64'(fetch_ready), 64'd1);
        @(posedge clk);
        #1 fetch_valid = 1'b0;
        @(negedge clk);
        #1 check_slot(21, 0, 2'b01, 1'b0);

        // Overlap on the final slot of a 2-slot bundle (R3, R8)
        @(negedge clk);
        chk(issue_idx == 2'd1, "R3 short last", 64'(issue_idx), 64'd1);
        fetch_valid  = 1'b1;
        fetch_bundle = mk_bundle(22, 2'b00);
        #1 chk(fetch_ready == 1'b1, "R8 ready on short last", 64'(fetch_ready), 64'd1);
        @(posedge clk);
        #1 fetch_valid = 1'b0;
        @(negedge clk);
        #1 chk(issue_valid && issue_idx == 2'd0 && issue_slot == mk_slot(22, 0),
               "R8 no bubble", 64'(issue_slot), 64'(mk_slot(22, 0)));

        // Reset mid-bundle (R9)
        @(negedge clk);
        chk(issue_idx == 2'd1, "R2 before reset", 64'(issue_idx), 64'd1);
        rst_n = 1'b0;
        #1 chk(issue_valid == 1'b0, "R9 discard", 64'(issue_valid), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        send(mk_bundle(23, 2'b10));
        @(negedge clk);
        cmp_flag = 1'b0;
        #1 check_slot(23, 0, 2'b10, 1'b0);

        @(negedge clk);
        finish_up();
    end
endmodule